// File: doc/BRIEF.md
# Transmit Beamformer Channel Delay and Burst Sequencer

This block is one channel of a transmit beamformer for an ultrasonic array. Each channel holds its own firing delay, pulse width and burst length. A fire trigger and a reference clock are shared by all channels. When the trigger arrives, the channel waits out its programmed delay and then sends a burst of excitation pulses to a high-voltage pulser stage outside the block.

The 16-bit delay word is in units of 1 ns, and it is split into two parts. The upper 13 bits count whole periods of the 8 ns reference clock. The lower 3 bits form a tap-select code for an external delay line that is locked to one clock period and interpolates within it. The pulse width is set in clock periods, with a floor of three periods. The gap between pulses in a burst is equal to the width. One trigger can produce from 1 to 16 pulses.

Configuration goes into a shadow copy through a valid/acknowledge handshake. The shadow copy takes effect at the next accepted trigger. A trigger that arrives while the channel is busy is dropped, and the drop is recorded in a sticky flag.

Top module: `tx_fire_channel`

## Requirements
- R1: While reset is held and just after it, `pulse_out`, `done`, `busy`, `overrun` and `cfg_ack` are 0 and `tap_sel` is 0.
- R2: When `cfg_valid` is high on a rising edge, `cfg_ack` is high for the following cycle. When `cfg_valid` is low on a rising edge, `cfg_ack` is low for the following cycle.
- R3: Let C be `cfg_delay[15:3]` from the applied configuration. When `fire` is sampled at edge k while the channel is idle, `busy` rises at edge k and `pulse_out` first rises at edge k+C. With C = 0, the first pulse therefore rises at the edge that samples the trigger.
- R4: From the edge that accepts a trigger, `tap_sel` equals `cfg_delay[2:0]` of the applied configuration. It then stays constant until the next accepted trigger.
- R5: Every pulse is high for exactly W cycles, where W = `cfg_width` if that value is 3 or more, and W = 3 otherwise.
- R6: A burst contains `cfg_reps`+1 pulses (`cfg_reps` is 4 bits, so 1 to 16 pulses). Consecutive pulses are separated by W low cycles.
- R7: `done` is high for exactly one cycle, starting at the edge where the last pulse of the burst falls. `busy` drops at the next edge.
- R8: A configuration write made while a burst is running does not change that burst. The new values govern the next accepted trigger. A write made in the same cycle as an accepted trigger also applies only to the following trigger.
- R9: A trigger sampled while `busy` is high is ignored and does not disturb the burst in progress. It sets `overrun`, which stays set until reset.
- R10: `pulse_out` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 8 ns period |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_delay | input | 16 | Firing delay in ns; [15:3] coarse periods, [2:0] fine tap |
| cfg_width | input | 8 | Pulse width in clock periods (floor of 3) |
| cfg_reps | input | 4 | Pulses per burst minus one |
| cfg_ack | output | 1 | Write acknowledge, one cycle after the strobe |
| fire | input | 1 | Shared fire trigger |
| tap_sel | output | 3 | Fine interpolation tap code for the external delay line |
| pulse_out | output | 1 | Pulser drive, high during each excitation pulse |
| done | output | 1 | One-cycle end-of-burst marker |
| busy | output | 1 | Channel is delaying, pulsing or finishing |
| overrun | output | 1 | Sticky flag for a trigger dropped while busy |

## Verification
The assertions assume that `fire` and `cfg_valid` are synchronous to `clk`. They also assume the programmed width never exceeds 255 periods, so the checker's high-time counter cannot wrap. The bench changes every input only at falling edges and keeps all field values inside their declared widths. It raises `fire` during a burst only on purpose, for the overrun case, so every other trigger lands on an idle channel. Expected waveforms are derived per cycle from the delay, width and repetition fields alone, and compared over the whole window from trigger to return to idle.

// File: rtl/tx_fire_channel.sv
module tx_fire_channel #(
  parameter int DELAY_W   = 16,
  parameter int FINE_W    = 3,
  parameter int WIDTH_W   = 8,
  parameter int REP_W     = 4,
  parameter int MIN_WIDTH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  input  logic [DELAY_W-1:0] cfg_delay,
  input  logic [WIDTH_W-1:0] cfg_width,
  input  logic [REP_W-1:0]   cfg_reps,
  output logic               cfg_ack,
  input  logic               fire,
  output logic [FINE_W-1:0]  tap_sel,
  output logic               pulse_out,
  output logic               done,
  output logic               busy,
  output logic               overrun
);
  localparam int COARSE_W = DELAY_W - FINE_W;
  localparam int CNT_W    = (COARSE_W > WIDTH_W) ? COARSE_W : WIDTH_W;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_HIGH, S_LOW, S_DONE} state_t;
  state_t state;

  logic [DELAY_W-1:0]  sh_delay;
  logic [WIDTH_W-1:0]  sh_width, sh_width_eff, act_width;
  logic [REP_W-1:0]    sh_reps, rep_left;
  logic [CNT_W-1:0]    cnt, width_ld;
  logic [COARSE_W-1:0] coarse;

  assign coarse       = sh_delay[DELAY_W-1:FINE_W];
  assign sh_width_eff = (sh_width < WIDTH_W'(MIN_WIDTH)) ? WIDTH_W'(MIN_WIDTH) : sh_width;
  assign width_ld     = CNT_W'(act_width) - CNT_W'(1);

  assign busy      = (state != S_IDLE);
  assign pulse_out = (state == S_HIGH);
  assign done      = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_delay <= '0;
      sh_width <= WIDTH_W'(MIN_WIDTH);
      sh_reps  <= '0;
      cfg_ack  <= 1'b0;
    end else begin
      cfg_ack <= cfg_valid;
      if (cfg_valid) begin
        sh_delay <= cfg_delay;
        sh_width <= cfg_width;
        sh_reps  <= cfg_reps;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      act_width <= WIDTH_W'(MIN_WIDTH);
      rep_left  <= '0;
      tap_sel   <= '0;
      overrun   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (fire) begin
          tap_sel   <= sh_delay[FINE_W-1:0];
          act_width <= sh_width_eff;
          rep_left  <= sh_reps;
          if (coarse == '0) begin
            state <= S_HIGH;
            cnt   <= CNT_W'(sh_width_eff) - CNT_W'(1);
          end else begin
            state <= S_WAIT;
            cnt   <= CNT_W'(coarse) - CNT_W'(1);
          end
        end
        S_WAIT: if (cnt == '0) begin
          state <= S_HIGH;
          cnt   <= width_ld;
        end else cnt <= cnt - CNT_W'(1);
        S_HIGH: if (cnt == '0) begin
          if (rep_left == '0) state <= S_DONE;
          else begin
            state <= S_LOW;
            cnt   <= width_ld;
          end
        end else cnt <= cnt - CNT_W'(1);
        S_LOW: if (cnt == '0) begin
          state    <= S_HIGH;
          cnt      <= width_ld;
          rep_left <= rep_left - REP_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (fire && state != S_IDLE) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_fire_channel_chk.sv
module tx_fire_channel_chk #(
  parameter int FINE_W    = 3,
  parameter int MIN_WIDTH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_valid,
  input logic              cfg_ack,
  input logic              fire,
  input logic [FINE_W-1:0] tap_sel,
  input logic              pulse_out,
  input logic              done,
  input logic              busy,
  input logic              overrun
);
  logic [8:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_run <= '0;
    else if (pulse_out) hi_run <= hi_run + 9'd1;
    else hi_run <= '0;
  end

  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) cfg_valid |=> cfg_ack); // R2
  AST_FIRE_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (fire && !busy) |=> busy); // R3
  AST_TAP_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(tap_sel)); // R4
  AST_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (!pulse_out && $past(pulse_out)) |-> hi_run >= 9'(MIN_WIDTH)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(pulse_out)); // R7
  AST_DONE_IDLES: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !pulse_out); // R10
endmodule

bind tx_fire_channel tx_fire_channel_chk #(.FINE_W(FINE_W), .MIN_WIDTH(MIN_WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ack(cfg_ack), .fire(fire),
  .tap_sel(tap_sel), .pulse_out(pulse_out), .done(done), .busy(busy), .overrun(overrun)
);

// File: tb/tb_tx_fire_channel.sv
module tb_tx_fire_channel;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cfg_valid, fire;
  logic [15:0] cfg_delay;
  logic [7:0]  cfg_width;
  logic [3:0]  cfg_reps;
  logic        cfg_ack, pulse_out, done, busy, overrun;
  logic [2:0]  tap_sel;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  tx_fire_channel dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_delay(cfg_delay),
    .cfg_width(cfg_width), .cfg_reps(cfg_reps), .cfg_ack(cfg_ack), .fire(fire),
    .tap_sel(tap_sel), .pulse_out(pulse_out), .done(done), .busy(busy), .overrun(overrun)
  );

  // {delay, width, reps, expected coarse periods, expected effective width}
  localparam logic [48:0] VEC [8] = '{
    {16'h0000, 8'd4,   4'd0,  13'd0,    8'd4},
    {16'h0005, 8'd1,   4'd2,  13'd0,    8'd3},
    {16'h0028, 8'd3,   4'd1,  13'd5,    8'd3},
    {16'h0013, 8'd0,   4'd15, 13'd2,    8'd3},
    {16'h00FF, 8'd10,  4'd3,  13'd31,   8'd10},
    {16'hFFFF, 8'd2,   4'd0,  13'd8191, 8'd3},
    {16'h0009, 8'd255, 4'd1,  13'd1,    8'd255},
    {16'h0101, 8'd6,   4'd4,  13'd32,   8'd6}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic write_cfg(input logic [15:0] d, input logic [7:0] w, input logic [3:0] r);
    cfg_delay = d; cfg_width = w; cfg_reps = r; cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk("R2 ack after write", {31'd0, cfg_ack}, 1);
    @(negedge clk);
    chk("R2 ack drops", {31'd0, cfg_ack}, 0);
  endtask

  task automatic run_burst(input logic [15:0] d, input int r, input int ec, input int ew,
                           input bit mid_wr, input logic [15:0] nd, input logic [7:0] nw,
                           input logic [3:0] nr, input bit mid_fire);
    int n_pulses = r + 1;
    int last = ec + (2 * n_pulses - 1) * ew;
    fire = 1'b1;
    @(negedge clk);
    fire = 1'b0;
    for (int i = 0; i <= last + 1; i++) begin
      bit ep = (i >= ec) && ((i - ec) < (2 * n_pulses - 1) * ew) && (((i - ec) % (2 * ew)) < ew);
      chk("R3 R5 R6 R8 R10 pulse", {31'd0, pulse_out}, {31'd0, ep});
      chk("R7 done", {31'd0, done}, {31'd0, (i == last)});
      chk("R3 R7 busy", {31'd0, busy}, {31'd0, (i <= last)});
      chk("R4 tap", {29'd0, tap_sel}, {29'd0, d[2:0]});
      if (mid_wr && i == 1) begin
        cfg_delay = nd; cfg_width = nw; cfg_reps = nr; cfg_valid = 1'b1;
      end else cfg_valid = 1'b0;
      fire = (mid_fire && i == 2);
      @(negedge clk);
    end
    fire = 1'b0;
    cfg_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cfg_valid = 1'b0; fire = 1'b0;
    cfg_delay = '0; cfg_width = '0; cfg_reps = '0;
    repeat (3) @(negedge clk);
    chk("R1 pulse in reset", {31'd0, pulse_out}, 0);
    chk("R1 done in reset", {31'd0, done}, 0);
    chk("R1 busy in reset", {31'd0, busy}, 0);
    chk("R1 overrun in reset", {31'd0, overrun}, 0);
    chk("R1 ack in reset", {31'd0, cfg_ack}, 0);
    chk("R1 tap in reset", {29'd0, tap_sel}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", {31'd0, busy}, 0);

    foreach (VEC[v]) begin
      write_cfg(VEC[v][48:33], VEC[v][32:25], VEC[v][24:21]);
      run_burst(VEC[v][48:33], int'(VEC[v][24:21]), int'(VEC[v][20:8]), int'(VEC[v][7:0]),
                1'b0, 16'h0, 8'h0, 4'h0, 1'b0);
    end

    // R8: write during a burst affects only the next one
    write_cfg(16'h0010, 8'd4, 4'd1);
    run_burst(16'h0010, 1, 2, 4, 1'b1, 16'h000E, 8'd5, 4'd2, 1'b0);
    run_burst(16'h000E, 2, 1, 5, 1'b0, 16'h0, 8'h0, 4'h0, 1'b0);

    // R8: write in the same cycle as the trigger applies to the following trigger
    write_cfg(16'h0008, 8'd3, 4'd0);
    cfg_delay = 16'h0003; cfg_width = 8'd7; cfg_reps = 4'd1; cfg_valid = 1'b1;
    run_burst(16'h0008, 0, 1, 3, 1'b0, 16'h0, 8'h0, 4'h0, 1'b0);
    run_burst(16'h0003, 1, 0, 7, 1'b0, 16'h0, 8'h0, 4'h0, 1'b0);

    // R9: trigger during a burst is dropped and flagged
    chk("R9 overrun clear before", {31'd0, overrun}, 0);
    write_cfg(16'h0002, 8'd3, 4'd2);
    run_burst(16'h0002, 2, 0, 3, 1'b0, 16'h0, 8'h0, 4'h0, 1'b1);
    chk("R9 overrun set", {31'd0, overrun}, 1);
    run_burst(16'h0002, 2, 0, 3, 1'b0, 16'h0, 8'h0, 4'h0, 1'b0);
    chk("R9 overrun sticky", {31'd0, overrun}, 1);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 overrun cleared by reset", {31'd0, overrun}, 0);
    chk("R1 tap cleared by reset", {29'd0, tap_sel}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule